// File: doc/BRIEF.md
# Keyed Register Write Guard

This block sits between a plain register write port and a bank of nine 32-bit configuration registers. It owns those registers and feeds their contents to the rest of the chip. While protection is on, it refuses every write into the bank and every software reset of the bank. Protection is turned on or off through a control word. That word changes the protection flag only when it carries a fixed 24-bit key.

Each refused action is recorded in a status word. A two-bit kind code says whether a register write, a software reset, or both were refused. A 16-bit source field names the register the most recent refused write aimed at. Reading the status word returns its contents and empties it in the same cycle. The read port is registered: data appears on `rd_data` one clock after `rd_en`.

Top module: `wp_keyed_guard`

## Requirements
- R1: After synchronous reset, protection is off, the status word reads 0 and all nine configuration registers read 0.
- R2: With protection off, a write to byte offset 4*i (i = 0..8) stores `wr_data` into register i. A read of that offset returns the value on `rd_data` one cycle after `rd_en`.
- R3: A write to offset 0xE4 whose bits 31:8 equal 0x495349 sets the protection flag to bit 0 of the data. This also works while protection is on. A read of 0xE4 returns the flag in bit 0, with all other bits 0.
- R4: A write to 0xE4 with any other value in bits 31:8 leaves the flag unchanged and records nothing in the status word.
- R5: With protection on, a write to register i leaves it unchanged. It sets status bit 0 (kind code 1) and loads i+1 (1..9) into status bits 23:8.
- R6: A software reset request with protection off clears all nine registers. With protection on, it changes no register, sets status bit 1 (kind code 2), and leaves the source field as it was.
- R7: Both kinds refused before a status read give kind code 3. The source field then holds the most recently refused register write.
- R8: A read of 0xE8 returns the kind code in bits 3:0 and the source in bits 23:8, and clears both. A violation in the same cycle as that read is not lost: the read returns the earlier contents and the new violation remains for the next read.
- R9: Writes to 0xE8 or to unmapped offsets change nothing and are never recorded. Reads of unmapped offsets return 0.
- R10: With protection off, a software reset and a register write in the same cycle leave all registers at 0. The reset wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |
| srst_req | input | 1 | Software reset request for the register bank |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Read data, valid one cycle after `rd_en` |
| cfg_out | output | 288 | Nine configuration registers, register i at bits 32*i+31:32*i |

## Verification
Two functions can land in the same clock: the clearing read of the status word, and the recording of a new refused write or refused reset. The bench provokes this on purpose with directed cycles that issue a status read together with a protected write, and together with a protected reset request. Randomly mixed traffic also produces it often. A check passes when the read returns only the older contents and the following read shows exactly the new violation with its source.

// File: rtl/wp_pkg.sv
// Package: shared constants and the violation kind encoding for the keyed
// write guard. Assumes byte-addressed, word-aligned register offsets.
package wp_pkg;
    localparam int unsigned WP_DATA_W   = 32;
    localparam int unsigned WP_ADDR_W   = 8;
    localparam int unsigned WP_N_CFG    = 9;
    localparam int unsigned WP_KEY_W    = 24;
    localparam logic [23:0] WP_KEY      = 24'h495349;
    localparam int unsigned WP_TYPE_W   = 4;
    localparam int unsigned WP_SRC_W    = 16;
    localparam int unsigned WP_SRC_LSB  = 8;

    // Kind of refused action; bit 0 = register write, bit 1 = software reset
    typedef enum logic [1:0] {
        VK_NONE  = 2'b00,
        VK_WRITE = 2'b01,
        VK_SRST  = 2'b10,
        VK_BOTH  = 2'b11
    } viol_kind_e;
endpackage

// File: rtl/wp_addr_decode.sv
// Module: wp_addr_decode
// Purpose: classifies a byte offset as a configuration register (with its
// index), the protection control word, or the status word.
// Assumes: configuration registers are word aligned from offset 0 upward;
// IDX_W + 2 <= ADDR_W.
module wp_addr_decode #(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned N_CFG    = 9,
    parameter int unsigned IDX_W    = 4,
    parameter logic [7:0]  CTRL_OFF = 8'hE4,
    parameter logic [7:0]  STAT_OFF = 8'hE8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_cfg,
    output logic [IDX_W-1:0]  idx,
    output logic              hit_ctrl,
    output logic              hit_stat
);
    localparam int unsigned WORD_W = ADDR_W - 2;

    // Decode the offset into the three register classes
    always_comb begin
        hit_cfg  = (addr[1:0] == 2'b00) && (addr[ADDR_W-1:2] < WORD_W'(N_CFG));
        idx      = addr[IDX_W+1:2];
        hit_ctrl = (addr == ADDR_W'(CTRL_OFF));
        hit_stat = (addr == ADDR_W'(STAT_OFF));
    end
endmodule

// File: rtl/wp_guard.sv
// Module: wp_guard
// Purpose: holds the protection flag, checks the key on control writes,
// decides which bank writes and resets may proceed, and accumulates the
// violation status with clear-on-read.
// Assumes: the caller qualifies ctrl_wr, cfg_wr and stat_rd with the strobes.
module wp_guard
    import wp_pkg::*;
#(
    parameter int unsigned KEY_W  = 24,
    parameter logic [23:0] KEY    = 24'h495349,
    parameter int unsigned IDX_W  = 4,
    parameter int unsigned TYPE_W = 4,
    parameter int unsigned SRC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [KEY_W-1:0]  ctrl_key,
    input  logic              ctrl_en_bit,
    input  logic              cfg_wr,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic              srst_req,
    input  logic              stat_rd,
    output logic              prot_en,
    output logic              cfg_wr_ok,
    output logic              srst_ok,
    output logic [TYPE_W-1:0] viol_type,
    output logic [SRC_W-1:0]  viol_src
);
    logic       key_match;
    viol_kind_e kind_now;
    logic [TYPE_W-1:0] type_base;
    logic [SRC_W-1:0]  src_base;

    // Gate bank actions by the current protection flag
    always_comb begin
        key_match = (ctrl_key == KEY_W'(KEY));
        cfg_wr_ok = cfg_wr & ~prot_en;
        srst_ok   = srst_req & ~prot_en;
        kind_now  = viol_kind_e'({srst_req & prot_en, cfg_wr & prot_en});
        type_base = stat_rd ? '0 : viol_type;
        src_base  = stat_rd ? '0 : viol_src;
    end

    // Protection flag: updated only by a control write carrying the key
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_en <= 1'b0;
        end else if (ctrl_wr && key_match) begin
            prot_en <= ctrl_en_bit;
        end
    end

    // Status: clear on read, then merge this cycle's refusals
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_type <= '0;
            viol_src  <= '0;
        end else begin
            viol_type <= type_base | TYPE_W'(kind_now);
            if (kind_now == VK_WRITE || kind_now == VK_BOTH) begin
                viol_src <= SRC_W'(cfg_idx) + SRC_W'(1);
            end else begin
                viol_src <= src_base;
            end
        end
    end
endmodule

// File: rtl/wp_regbank.sv
// Module: wp_regbank
// Purpose: the protected configuration registers with a bank-wide clear
// and a read multiplexer.
// Assumes: clear and write permissions are already resolved by the guard;
// clear has priority over a write in the same cycle.
module wp_regbank #(
    parameter int unsigned N_CFG  = 9,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr_all,
    input  logic                    wr_ok,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic [DATA_W-1:0]       rd_word,
    output logic [N_CFG*DATA_W-1:0] cfg_flat
);
    for (genvar g = 0; g < N_CFG; g++) begin : g_reg
        logic [DATA_W-1:0] q;

        // One register: reset or bank clear, else a permitted write
        always_ff @(posedge clk) begin
            if (!rst_n || clr_all) begin
                q <= '0;
            end else if (wr_ok && (wr_idx == IDX_W'(g))) begin
                q <= wr_data;
            end
        end

        assign cfg_flat[g*DATA_W +: DATA_W] = q;
    end

    // Select the addressed register for the read path
    always_comb begin
        rd_word = '0;
        for (int i = 0; i < N_CFG; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_word = cfg_flat[i*DATA_W +: DATA_W];
            end
        end
    end
endmodule

// File: rtl/wp_keyed_guard.sv
// Module: wp_keyed_guard (top)
// Purpose: keyed write protection around nine configuration registers, with
// a protection control word, a clear-on-read violation status word and a
// registered read port.
// Assumes: one write and one read per cycle; rd_data valid the cycle after
// rd_en and held until the next read.
module wp_keyed_guard
    import wp_pkg::*;
#(
    parameter int unsigned DATA_W   = WP_DATA_W,
    parameter int unsigned ADDR_W   = WP_ADDR_W,
    parameter int unsigned N_CFG    = WP_N_CFG,
    parameter int unsigned KEY_W    = WP_KEY_W,
    parameter logic [23:0] KEY      = WP_KEY,
    parameter logic [7:0]  CTRL_OFF = 8'hE4,
    parameter logic [7:0]  STAT_OFF = 8'hE8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic                    srst_req,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [DATA_W-1:0]       rd_data,
    output logic [N_CFG*DATA_W-1:0] cfg_out
);
    localparam int unsigned IDX_W   = $clog2(N_CFG);
    localparam int unsigned TYPE_W  = WP_TYPE_W;
    localparam int unsigned SRC_W   = WP_SRC_W;
    localparam int unsigned SRC_LSB = WP_SRC_LSB;

    logic             w_hit_cfg, w_hit_ctrl, w_hit_stat;
    logic [IDX_W-1:0] w_idx;
    logic             r_hit_cfg, r_hit_ctrl, r_hit_stat;
    logic [IDX_W-1:0] r_idx;
    logic             prot_en, cfg_wr_ok, srst_ok, stat_rd;
    logic [TYPE_W-1:0] viol_type;
    logic [SRC_W-1:0]  viol_src;
    logic [DATA_W-1:0] bank_word, stat_word, rd_next;
    logic              w_unused_stat;

    wp_addr_decode #(
        .ADDR_W(ADDR_W), .N_CFG(N_CFG), .IDX_W(IDX_W),
        .CTRL_OFF(CTRL_OFF), .STAT_OFF(STAT_OFF)
    ) u_wdec (
        .addr(wr_addr), .hit_cfg(w_hit_cfg), .idx(w_idx),
        .hit_ctrl(w_hit_ctrl), .hit_stat(w_hit_stat)
    );

    wp_addr_decode #(
        .ADDR_W(ADDR_W), .N_CFG(N_CFG), .IDX_W(IDX_W),
        .CTRL_OFF(CTRL_OFF), .STAT_OFF(STAT_OFF)
    ) u_rdec (
        .addr(rd_addr), .hit_cfg(r_hit_cfg), .idx(r_idx),
        .hit_ctrl(r_hit_ctrl), .hit_stat(r_hit_stat)
    );

    // Writes to the status word are decoded but deliberately have no effect
    assign w_unused_stat = w_hit_stat;
    assign stat_rd       = rd_en & r_hit_stat;

    wp_guard #(
        .KEY_W(KEY_W), .KEY(KEY), .IDX_W(IDX_W),
        .TYPE_W(TYPE_W), .SRC_W(SRC_W)
    ) u_guard (
        .clk(clk), .rst_n(rst_n),
        .ctrl_wr(wr_en & w_hit_ctrl),
        .ctrl_key(wr_data[DATA_W-1 -: KEY_W]),
        .ctrl_en_bit(wr_data[0]),
        .cfg_wr(wr_en & w_hit_cfg), .cfg_idx(w_idx),
        .srst_req(srst_req), .stat_rd(stat_rd),
        .prot_en(prot_en), .cfg_wr_ok(cfg_wr_ok), .srst_ok(srst_ok),
        .viol_type(viol_type), .viol_src(viol_src)
    );

    wp_regbank #(
        .N_CFG(N_CFG), .DATA_W(DATA_W), .IDX_W(IDX_W)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .clr_all(srst_ok),
        .wr_ok(cfg_wr_ok), .wr_idx(w_idx), .wr_data(wr_data),
        .rd_idx(r_idx), .rd_word(bank_word), .cfg_flat(cfg_out)
    );

    // Assemble the status word and pick the read source
    always_comb begin
        stat_word = '0;
        stat_word[TYPE_W-1:0] = viol_type;
        stat_word[SRC_LSB +: SRC_W] = viol_src;
        rd_next = '0;
        if (r_hit_cfg) begin
            rd_next = bank_word;
        end else if (r_hit_ctrl) begin
            rd_next = DATA_W'(prot_en);
        end else if (r_hit_stat) begin
            rd_next = stat_word | DATA_W'(w_unused_stat & 1'b0);
        end
    end

    // Registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= rd_next;
        end
    end
endmodule

// File: rtl/wp_keyed_guard_chk.sv
// Module: wp_keyed_guard_chk
// Purpose: temporal checks on the keyed write guard, bound into the top.
// Assumes: signal names of wp_keyed_guard as bound below.
module wp_keyed_guard_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned N_CFG  = 9,
    parameter int unsigned IDX_W  = 4,
    parameter int unsigned KEY_W  = 24,
    parameter logic [23:0] KEY    = 24'h495349,
    parameter int unsigned TYPE_W = 4,
    parameter int unsigned SRC_W  = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_en,
    input logic                    w_hit_cfg,
    input logic                    w_hit_ctrl,
    input logic [IDX_W-1:0]        w_idx,
    input logic [KEY_W-1:0]        key_in,
    input logic                    srst_req,
    input logic                    stat_rd,
    input logic                    prot_en,
    input logic [TYPE_W-1:0]       viol_type,
    input logic [SRC_W-1:0]        viol_src,
    input logic [N_CFG*DATA_W-1:0] cfg_out
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!prot_en && viol_type == '0 && viol_src == '0 && cfg_out == '0)); // R1

    AST_BAD_KEY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && w_hit_ctrl && key_in != KEY_W'(KEY)) |=> $stable(prot_en)); // R4

    AST_BLOCKED_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_en && wr_en && w_hit_cfg) |=> $stable(cfg_out)); // R5

    AST_BLOCKED_WRITE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_en && wr_en && w_hit_cfg) |=>
        (viol_type[0] && viol_src == SRC_W'($past(w_idx)) + SRC_W'(1))); // R5

    AST_SRST_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_en && srst_req) |=> (viol_type[1] && $stable(cfg_out))); // R6

    AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!prot_en && srst_req) |=> (cfg_out == '0)); // R10

    AST_STATUS_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !(prot_en && ((wr_en && w_hit_cfg) || srst_req))) |=>
        (viol_type == '0 && viol_src == '0)); // R8
endmodule

bind wp_keyed_guard wp_keyed_guard_chk #(
    .DATA_W(DATA_W), .N_CFG(N_CFG), .IDX_W(IDX_W),
    .KEY_W(KEY_W), .KEY(KEY), .TYPE_W(TYPE_W), .SRC_W(SRC_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .w_hit_cfg(w_hit_cfg), .w_hit_ctrl(w_hit_ctrl), .w_idx(w_idx),
    .key_in(wr_data[DATA_W-1 -: KEY_W]), .srst_req(srst_req),
    .stat_rd(stat_rd), .prot_en(prot_en), .viol_type(viol_type),
    .viol_src(viol_src), .cfg_out(cfg_out)
);

// File: tb/wp_keyed_guard_bench.sv
module wp_keyed_guard_bench;
    localparam logic [7:0]  CTRL = 8'hE4;
    localparam logic [7:0]  STAT = 8'hE8;
    localparam logic [23:0] KEY  = 24'h495349;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0, srst_req = 1'b0, rd_en = 1'b0;
    logic [7:0]   wr_addr = '0, rd_addr = '0;
    logic [31:0]  wr_data = '0;
    logic [31:0]  rd_data;
    logic [287:0] cfg_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] m_cfg [9];
    logic        m_en;
    logic [3:0]  m_type;
    logic [15:0] m_src;

    always #2 clk = ~clk;

    wp_keyed_guard u_wp_keyed_guard (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .srst_req(srst_req), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .cfg_out(cfg_out)
    );

    function automatic bit is_cfg(input logic [7:0] a);
        return (a[1:0] == 2'b00) && (a[7:2] < 6'd9);
    endfunction

    function automatic logic [31:0] model_read(input logic [7:0] a);
        if (is_cfg(a)) return m_cfg[a[7:2]];
        if (a == CTRL) return {31'b0, m_en};
        if (a == STAT) return {8'h00, m_src, 4'h0, m_type};
        return 32'h0;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 9; i++) m_cfg[i] = '0;
        m_en = 1'b0; m_type = '0; m_src = '0;
    endtask

    task automatic model_step(input logic we, input logic [7:0] wa, input logic [31:0] wd,
                              input logic sr, input logic srd);
        logic bw, br;
        bw = 1'b0; br = 1'b0;
        if (sr) begin
            if (m_en) br = 1'b1;
            else for (int i = 0; i < 9; i++) m_cfg[i] = '0;
        end
        if (we && is_cfg(wa)) begin
            if (m_en) bw = 1'b1;
            else if (!sr) m_cfg[wa[7:2]] = wd;
        end
        if (srd) begin m_type = '0; m_src = '0; end
        if (bw) begin m_type[0] = 1'b1; m_src = 16'(wa[7:2]) + 16'd1; end
        if (br) m_type[1] = 1'b1;
        if (we && wa == CTRL && wd[31:8] == KEY) m_en = wd[0];
    endtask

    // One cycle: drive at a falling edge, check read data at the next one
    task automatic step(input logic we, input logic [7:0] wa, input logic [31:0] wd,
                        input logic sr, input logic re, input logic [7:0] ra, input string tag);
        logic [31:0] exp;
        exp = model_read(ra);
        wr_en = we; wr_addr = wa; wr_data = wd; srst_req = sr; rd_en = re; rd_addr = ra;
        model_step(we, wa, wd, sr, re && ra == STAT);
        @(negedge clk);
        if (re) check(tag, rd_data, exp);
        wr_en = 1'b0; srst_req = 1'b0; rd_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        step(1'b0, 8'h00, 32'h0, 1'b0, 1'b1, a, tag);
        check(tag, rd_data, exp);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
        step(1'b1, a, d, 1'b0, 1'b0, 8'h00, tag);
    endtask

    function automatic logic [7:0] pick_addr(input int unsigned r);
        if (r < 9) return 8'(r * 4);
        if (r == 9) return CTRL;
        if (r == 10) return STAT;
        return (r[0]) ? 8'h24 : 8'hF0;
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd_chk(CTRL, 32'h0, "R1 ctrl");
        rd_chk(STAT, 32'h0, "R1 status");
        for (int i = 0; i < 9; i++) rd_chk(8'(i * 4), 32'h0, "R1 cfg");

        // R2: unprotected writes reach the bank
        wr(8'h0C, 32'hA5A5_0003, "R2");
        wr(8'h20, 32'h1234_5678, "R2");
        rd_chk(8'h0C, 32'hA5A5_0003, "R2 reg3");
        rd_chk(8'h20, 32'h1234_5678, "R2 reg8");
        check("R2 cfg_out", cfg_out[8*32 +: 32], 32'h1234_5678);

        // R9: unmapped and status writes do nothing
        wr(8'h24, 32'hFFFF_FFFF, "R9");
        wr(STAT, 32'hFFFF_FFFF, "R9");
        rd_chk(8'h24, 32'h0, "R9 unmapped read");
        rd_chk(STAT, 32'h0, "R9 status untouched");

        // R3: keyed enable
        wr(CTRL, {KEY, 8'h01}, "R3");
        rd_chk(CTRL, 32'h1, "R3 enabled");

        // R4: wrong key cannot disable, records nothing
        wr(CTRL, {24'h495348, 8'h00}, "R4");
        rd_chk(CTRL, 32'h1, "R4 still on");
        rd_chk(STAT, 32'h0, "R4 no violation");

        // R5: protected write refused and recorded
        wr(8'h20, 32'hDEAD_BEEF, "R5");
        rd_chk(8'h20, 32'h1234_5678, "R5 reg8 kept");
        rd_chk(STAT, 32'h0000_0901, "R5 status");
        rd_chk(STAT, 32'h0, "R8 cleared");

        // R6/R7: refused reset, then refused write to reg0
        step(1'b0, 8'h00, 32'h0, 1'b1, 1'b0, 8'h00, "R6");
        rd_chk(8'h0C, 32'hA5A5_0003, "R6 reg3 kept");
        rd_chk(STAT, 32'h0000_0002, "R6 status");
        step(1'b0, 8'h00, 32'h0, 1'b1, 1'b0, 8'h00, "R7");
        wr(8'h04, 32'h1111_1111, "R7");
        wr(8'h00, 32'h2222_2222, "R7");
        rd_chk(STAT, 32'h0000_0103, "R7 both kinds");

        // R8: violation in the same cycle as the clearing read
        step(1'b1, 8'h08, 32'h5555_5555, 1'b0, 1'b1, STAT, "R8 same-cycle write");
        check("R8 old value", rd_data, 32'h0);
        rd_chk(STAT, 32'h0000_0301, "R8 kept write");
        step(1'b0, 8'h00, 32'h0, 1'b1, 1'b1, STAT, "R8 same-cycle reset");
        rd_chk(STAT, 32'h0000_0002, "R8 kept reset");

        // R3: disable with key while protected; R10: reset beats write
        wr(CTRL, {KEY, 8'hFE}, "R3");
        rd_chk(CTRL, 32'h0, "R3 disabled");
        step(1'b1, 8'h0C, 32'h7777_7777, 1'b1, 1'b0, 8'h00, "R10");
        rd_chk(8'h0C, 32'h0, "R10 reg3 zero");
        check("R10 bank zero", cfg_out[31:0] | cfg_out[8*32 +: 32], 32'h0);

        // Random mix checked against the model
        for (int n = 0; n < 1500; n++) begin
            int unsigned rw, rr;
            logic [31:0] d;
            logic [7:0] wa;
            rw = $urandom % 12;
            rr = $urandom % 12;
            wa = pick_addr(rw);
            d = $urandom;
            if (wa == CTRL && ($urandom % 2 == 0)) d[31:8] = KEY;
            step(($urandom % 3) != 0, wa, d, ($urandom % 16) == 0,
                 ($urandom % 2) == 0, pick_addr(rr), "R2-R9 random");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule